// File: doc/BRIEF.md
# Keyboard controller command processor

This block is the host-side register front end of a legacy PC keyboard and auxiliary-device controller. The host sees two byte-wide locations chosen by `host_sel`. With `host_sel` low it reaches the data location: a read returns the head of an external reply queue and pops it, and a write is routed by a pending-command register. With `host_sel` high it reaches the command location: a read returns the status byte and a write is decoded as a controller command.

The block holds the mode byte, the status flags and the output-port byte. It decodes single-byte commands and two-stage commands that consume the next data write. Replies go out as one-cycle pushes into a keyboard-side reply path, with a flag that marks a byte as auxiliary-sourced. Bytes bound for the keyboard or auxiliary device appear as one-cycle strobes. It also drives the A20 gate, a timed CPU reset pulse, the scan-code translation enable and two interrupt levels. The interrupt levels follow the external pending flags.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset the status byte reads 0x18, the mode byte is 0x03, the output-port byte is 0xCF, `a20_o` is 1, and `cpu_rst_o`, `xlat_en_o`, both interrupts and all strobes are 0.
- R2: Status bit 3 is 1 after a write to the command location and 0 after a write to the data location.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm the pending-command register. The next data write is routed by it, and every data write then clears it to zero, so a following data write is routed as if nothing were armed.
- R4: A data write with nothing armed pulses `kbd_tx_o` with the byte on `tx_data_o`. After 0xD4 it pulses `aux_tx_o` instead. The strobe is visible in the cycle after the write edge.
- R5: A data write after 0x60 loads the mode byte, and `xlat_en_o` follows mode bit 6.
- R6: A data write after 0xD2 pushes that byte as a reply with `rep_aux_o`=0. After 0xD3 it is pushed with `rep_aux_o`=1.
- R7: Replies with `rep_aux_o`=0 are: the mode byte for 0x20, the output-port byte for 0xD0 (bit 4 = any pending, bit 5 = only auxiliary pending), 0x80 for 0xC0, 0x00 for 0xA9 and 0xAB, and 0x55 for 0xAA, which also sets status bit 2.
- R8: 0xA7 and 0xA8 set and clear mode bit 5. 0xAD and 0xAE set and clear mode bit 4.
- R9: 0xDF sets output-port bit 1 and 0xDD clears it. A data write after 0xD1 stores the whole output-port byte. `a20_o` always equals output-port bit 1.
- R10: A command whose upper nibble is 0xF and whose bit 0 is 0 starts a CPU reset pulse `cpu_rst_o` lasting CLK_MHZ*RST_US cycles (750 by default). With bit 0 equal to 1 it does nothing.
- R11: An output-port write (after 0xD1) with bit 0 equal to 0 also starts the CPU reset pulse.
- R12: Status bit 0 is 1 when either pending flag is set, and status bit 5 is 1 only when the auxiliary flag alone is set. `irq_kbd_o` = keyboard pending AND mode bit 0 AND NOT mode bit 4. `irq_aux_o` = only auxiliary pending AND mode bit 1.
- R13: An unsupported command code changes no state and produces no reply, strobe or reset pulse.
- R14: A data-location read returns `rq_head_i` on `host_rdata` and raises `rq_pop_o`. A command-location read does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 = data location, 1 = command/status location |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or reply queue head |
| rq_head_i | input | 8 | Head byte of the external reply queue |
| rq_pop_o | output | 1 | Pop request to the reply queue |
| kbd_pend_i | input | 1 | Keyboard reply data waiting |
| aux_pend_i | input | 1 | Auxiliary reply data waiting |
| rep_valid_o | output | 1 | One-cycle reply push |
| rep_aux_o | output | 1 | Reply is auxiliary-sourced |
| rep_data_o | output | 8 | Reply byte |
| kbd_tx_o | output | 1 | Byte forwarded to the keyboard device |
| aux_tx_o | output | 1 | Byte forwarded to the auxiliary device |
| tx_data_o | output | 8 | Forwarded byte |
| xlat_en_o | output | 1 | Scan-code translation enable |
| a20_o | output | 1 | A20 gate |
| cpu_rst_o | output | 1 | CPU reset pulse |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_aux_o | output | 1 | Auxiliary interrupt level |

## Verification
The hardest case to reach is the CPU reset pulse started through a two-stage output-port write. The 0xD1 arm must survive until the data byte arrives, and the data byte must carry bit 0 low but bit 1 high, so that the reset fires while A20 is left alone. The bench builds this from back-to-back command and data writes. It then counts every cycle that `cpu_rst_o` stays high against the length worked out from the clock and duration parameters. It also counts the cycles of the folded 0xFE and 0xF0 commands, and confirms that 0xF1 and 0xFF start no pulse. The interrupt priority between keyboard and auxiliary pending is reached by driving both pending inputs together while the keyboard-disable mode bit is toggled.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_RD_MODE  = 8'h20;
  localparam logic [7:0] OP_WR_MODE  = 8'h60;
  localparam logic [7:0] OP_AUX_OFF  = 8'hA7;
  localparam logic [7:0] OP_AUX_ON   = 8'hA8;
  localparam logic [7:0] OP_AUX_TEST = 8'hA9;
  localparam logic [7:0] OP_SELFTEST = 8'hAA;
  localparam logic [7:0] OP_KBD_TEST = 8'hAB;
  localparam logic [7:0] OP_KBD_OFF  = 8'hAD;
  localparam logic [7:0] OP_KBD_ON   = 8'hAE;
  localparam logic [7:0] OP_RD_IN    = 8'hC0;
  localparam logic [7:0] OP_RD_OUT   = 8'hD0;
  localparam logic [7:0] OP_WR_OUT   = 8'hD1;
  localparam logic [7:0] OP_WR_KQ    = 8'hD2;
  localparam logic [7:0] OP_WR_AQ    = 8'hD3;
  localparam logic [7:0] OP_WR_AUX   = 8'hD4;
  localparam logic [7:0] OP_GATE_LO  = 8'hDD;
  localparam logic [7:0] OP_GATE_HI  = 8'hDF;

  localparam logic [7:0] MODE_INIT = 8'h03;
  localparam logic [7:0] PORT_INIT = 8'hCF;

  typedef enum logic [3:0] {
    CK_IGNORE, CK_ARM, CK_Q_MODE, CK_Q_PORT, CK_Q_CONST, CK_SELFTEST,
    CK_AUX_OFF, CK_AUX_ON, CK_KBD_OFF, CK_KBD_ON, CK_GATE_HI, CK_GATE_LO,
    CK_CPU_RST
  } cmd_kind_e;

  // Pulse family folds first: upper nibble F, low bit picks reset or no-op.
  function automatic cmd_kind_e classify(input logic [7:0] op);
    if (op[7:4] == 4'hF) return op[0] ? CK_IGNORE : CK_CPU_RST;
    case (op)
      OP_WR_MODE, OP_WR_OUT, OP_WR_KQ, OP_WR_AQ, OP_WR_AUX: return CK_ARM;
      OP_RD_MODE:                         return CK_Q_MODE;
      OP_RD_OUT:                          return CK_Q_PORT;
      OP_RD_IN, OP_AUX_TEST, OP_KBD_TEST: return CK_Q_CONST;
      OP_SELFTEST:                        return CK_SELFTEST;
      OP_AUX_OFF:                         return CK_AUX_OFF;
      OP_AUX_ON:                          return CK_AUX_ON;
      OP_KBD_OFF:                         return CK_KBD_OFF;
      OP_KBD_ON:                          return CK_KBD_ON;
      OP_GATE_HI:                         return CK_GATE_HI;
      OP_GATE_LO:                         return CK_GATE_LO;
      default:                            return CK_IGNORE;
    endcase
  endfunction

  function automatic logic [7:0] fixed_reply(input logic [7:0] op);
    case (op)
      OP_RD_IN:    return 8'h80;
      OP_SELFTEST: return 8'h55;
      default:     return 8'h00;
    endcase
  endfunction

  // Output port as read back: bits 4/5 mirror the live buffer flags.
  function automatic logic [7:0] port_view(input logic [7:0] stored,
                                           input logic any_full,
                                           input logic aux_only);
    return {stored[7:6], aux_only, any_full, stored[3:0]};
  endfunction
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output cmd_kind_e         kind_o,
  output logic [BYTE_W-1:0] const_o
);
  always_comb begin
    kind_o  = classify(op_i);
    const_o = fixed_reply(op_i);
  end
endmodule

// File: rtl/kbc_flag_logic.sv
module kbc_flag_logic
  import kbc_pkg::*;
(
  input  logic              kbd_pend_i,
  input  logic              aux_pend_i,
  input  logic [BYTE_W-1:0] mode_i,
  input  logic              self_ok_i,
  input  logic              last_cmd_i,
  output logic [BYTE_W-1:0] status_o,
  output logic              any_full_o,
  output logic              aux_only_o,
  output logic              irq_kbd_o,
  output logic              irq_aux_o
);
  always_comb begin
    any_full_o = kbd_pend_i | aux_pend_i;
    aux_only_o = aux_pend_i & ~kbd_pend_i;   // keyboard data wins
    status_o   = {2'b00, aux_only_o, 1'b1, last_cmd_i, self_ok_i, 1'b0, any_full_o};
    irq_kbd_o  = kbd_pend_i & mode_i[0] & ~mode_i[4];
    irq_aux_o  = aux_only_o & mode_i[1];
  end
endmodule

// File: rtl/kbc_rst_pulse.sv
module kbc_rst_pulse #(
  parameter int CYCLES = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (trig_i)         left_q <= CW'(CYCLES);
    else if (left_q != '0)   left_q <= left_q - CW'(1);
  end
  assign pulse_o = (left_q != '0);

  p_pulse_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o);
  p_pulse_no_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> !$past(trig_i));
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int RST_US  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic [BYTE_W-1:0] rq_head_i,
  output logic              rq_pop_o,
  input  logic              kbd_pend_i,
  input  logic              aux_pend_i,
  output logic              rep_valid_o,
  output logic              rep_aux_o,
  output logic [BYTE_W-1:0] rep_data_o,
  output logic              kbd_tx_o,
  output logic              aux_tx_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              xlat_en_o,
  output logic              a20_o,
  output logic              cpu_rst_o,
  output logic              irq_kbd_o,
  output logic              irq_aux_o
);
  localparam int RST_CYCLES = CLK_MHZ * RST_US;

  logic [BYTE_W-1:0] mode_q, port_q, armed_q, status, const_rep;
  logic              self_q, lastcmd_q, any_full, aux_only;
  cmd_kind_e         kind;

  // Named events for the checks below.
  logic cmd_wr, dat_wr, rst_req;
  assign cmd_wr  = host_we &  host_sel;
  assign dat_wr  = host_we & ~host_sel;
  assign rst_req = (cmd_wr && kind == CK_CPU_RST) ||
                   (dat_wr && armed_q == OP_WR_OUT && !host_wdata[0]);

  kbc_cmd_decode u_dec (.op_i(host_wdata), .kind_o(kind), .const_o(const_rep));

  kbc_flag_logic u_flags (
    .kbd_pend_i(kbd_pend_i), .aux_pend_i(aux_pend_i), .mode_i(mode_q),
    .self_ok_i(self_q), .last_cmd_i(lastcmd_q), .status_o(status),
    .any_full_o(any_full), .aux_only_o(aux_only),
    .irq_kbd_o(irq_kbd_o), .irq_aux_o(irq_aux_o));

  kbc_rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig_i(rst_req), .pulse_o(cpu_rst_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_INIT;
      port_q      <= PORT_INIT;
      armed_q     <= '0;
      self_q      <= 1'b0;
      lastcmd_q   <= 1'b1;
      rep_valid_o <= 1'b0;
      rep_aux_o   <= 1'b0;
      rep_data_o  <= '0;
      kbd_tx_o    <= 1'b0;
      aux_tx_o    <= 1'b0;
      tx_data_o   <= '0;
    end else begin
      rep_valid_o <= 1'b0;
      rep_aux_o   <= 1'b0;
      kbd_tx_o    <= 1'b0;
      aux_tx_o    <= 1'b0;
      if (host_we) lastcmd_q <= host_sel;
      if (cmd_wr) begin
        case (kind)
          CK_ARM:      armed_q <= host_wdata;
          CK_Q_MODE:   begin rep_valid_o <= 1'b1; rep_data_o <= mode_q; end
          CK_Q_PORT:   begin
            rep_valid_o <= 1'b1;
            rep_data_o  <= port_view(port_q, any_full, aux_only);
          end
          CK_Q_CONST:  begin rep_valid_o <= 1'b1; rep_data_o <= const_rep; end
          CK_SELFTEST: begin
            self_q      <= 1'b1;
            rep_valid_o <= 1'b1;
            rep_data_o  <= const_rep;
          end
          CK_AUX_OFF:  mode_q[5] <= 1'b1;
          CK_AUX_ON:   mode_q[5] <= 1'b0;
          CK_KBD_OFF:  mode_q[4] <= 1'b1;
          CK_KBD_ON:   mode_q[4] <= 1'b0;
          CK_GATE_HI:  port_q[1] <= 1'b1;
          CK_GATE_LO:  port_q[1] <= 1'b0;
          default: ;
        endcase
      end
      if (dat_wr) begin
        armed_q <= '0;
        case (armed_q)
          OP_WR_MODE: mode_q <= host_wdata;
          OP_WR_OUT:  port_q <= host_wdata;
          OP_WR_KQ:   begin rep_valid_o <= 1'b1; rep_data_o <= host_wdata; end
          OP_WR_AQ:   begin
            rep_valid_o <= 1'b1;
            rep_aux_o   <= 1'b1;
            rep_data_o  <= host_wdata;
          end
          OP_WR_AUX:  begin aux_tx_o <= 1'b1; tx_data_o <= host_wdata; end
          default:    begin kbd_tx_o <= 1'b1; tx_data_o <= host_wdata; end
        endcase
      end
    end
  end

  assign xlat_en_o  = mode_q[6];
  assign a20_o      = port_q[1];
  assign host_rdata = host_sel ? status : rq_head_i;
  assign rq_pop_o   = host_re & ~host_sel;

  p_arm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> (armed_q == '0));
  p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rep_valid_o, kbd_tx_o, aux_tx_o}));
  p_reply_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid_o |-> $past(host_we));
  p_gate_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_we) |-> $stable(a20_o));
  p_irq_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_kbd_o, irq_aux_o}));
  p_pop_data_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rq_pop_o |-> !host_sel);
endmodule

// File: tb/kbc_cmd_proc_tb_top.sv
module kbc_cmd_proc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_we = 1'b0, host_re = 1'b0;
  logic [7:0] host_wdata = '0, rq_head = '0;
  logic       kbd_pend = 1'b0, aux_pend = 1'b0;
  logic [7:0] host_rdata, rep_data, tx_data;
  logic       rq_pop, rep_valid, rep_aux, kbd_tx, aux_tx;
  logic       xlat_en, a20, cpu_rst, irq_kbd, irq_aux;

  int total = 0, bad = 0;
  bit done = 0;
  localparam int PULSE_EXP = 125 * 6;

  logic [9:0] exp_q[$];   // {kind[1:0], byte}: 0 kbd reply, 1 aux reply, 2 kbd tx, 3 aux tx
  string      tag_q[$];

  always #4 clk = ~clk;

  kbc_cmd_proc dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rq_head_i(rq_head), .rq_pop_o(rq_pop), .kbd_pend_i(kbd_pend),
    .aux_pend_i(aux_pend), .rep_valid_o(rep_valid), .rep_aux_o(rep_aux),
    .rep_data_o(rep_data), .kbd_tx_o(kbd_tx), .aux_tx_o(aux_tx),
    .tx_data_o(tx_data), .xlat_en_o(xlat_en), .a20_o(a20),
    .cpu_rst_o(cpu_rst), .irq_kbd_o(irq_kbd), .irq_aux_o(irq_aux));

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(string tag, logic [1:0] k, logic [7:0] b);
    exp_q.push_back({k, b});
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic sel, logic [7:0] b);
    @(negedge clk);
    host_sel = sel; host_we = 1'b1; host_wdata = b;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic status_is(string tag, logic [7:0] mask, logic [7:0] exp);
    host_sel = 1'b1; host_re = 1'b1; #1;
    check(tag, {2'b00, host_rdata & mask}, {2'b00, exp});
    check({tag, " no pop"}, {9'd0, rq_pop}, 10'd0);
    host_re = 1'b0; host_sel = 1'b0;
  endtask

  task automatic pulse_len(string tag, int exp);
    int n = 0;
    while (cpu_rst && n < 2000) begin n++; @(negedge clk); end
    check(tag, 10'(n), 10'(exp));
  endtask

  // Monitor: every reply or forwarded byte must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && (rep_valid || kbd_tx || aux_tx)) begin
      logic [9:0] got;
      got = rep_valid ? {1'b0, rep_aux, rep_data} :
            kbd_tx    ? {2'b10, tx_data} : {2'b11, tx_data};
      if (exp_q.size() == 0) check("R13 unexpected event", got, 10'h3FF);
      else begin
        string t;
        logic [9:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, got, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    status_is("R1 status", 8'hFF, 8'h18);
    check("R1 a20", {9'd0, a20}, 10'd1);
    check("R1 outputs", {5'd0, cpu_rst, xlat_en, irq_kbd, irq_aux, 1'b0}, 10'd0);
    expect_ev("R1 mode reply", 2'd0, 8'h03);      wr(1, 8'h20);
    expect_ev("R1 port reply", 2'd0, 8'hCF);      wr(1, 8'hD0);
    // R2/R4 plain data write goes to keyboard
    expect_ev("R4 kbd tx", 2'd2, 8'h55);          wr(0, 8'h55);
    status_is("R2 data write", 8'h08, 8'h00);
    // R3/R4 aux forward, then cleared
    wr(1, 8'hD4);
    status_is("R2 cmd write", 8'h08, 8'h08);
    expect_ev("R4 aux tx", 2'd3, 8'h3C);          wr(0, 8'h3C);
    expect_ev("R3 cleared", 2'd2, 8'h3D);         wr(0, 8'h3D);
    // R6 injected replies
    wr(1, 8'hD2); expect_ev("R6 kbd q", 2'd0, 8'h9A); wr(0, 8'h9A);
    wr(1, 8'hD3); expect_ev("R6 aux q", 2'd1, 8'h9B); wr(0, 8'h9B);
    // R5 mode write
    wr(1, 8'h60); wr(0, 8'h47);
    check("R5 xlat on", {9'd0, xlat_en}, 10'd1);
    expect_ev("R5 mode read", 2'd0, 8'h47);       wr(1, 8'h20);
    wr(1, 8'h60); wr(0, 8'h03);
    check("R5 xlat off", {9'd0, xlat_en}, 10'd0);
    // R7 fixed replies
    expect_ev("R7 inport", 2'd0, 8'h80);          wr(1, 8'hC0);
    expect_ev("R7 aux test", 2'd0, 8'h00);        wr(1, 8'hA9);
    expect_ev("R7 kbd test", 2'd0, 8'h00);        wr(1, 8'hAB);
    expect_ev("R7 self test", 2'd0, 8'h55);       wr(1, 8'hAA);
    status_is("R7 self bit", 8'hFF, 8'h1C);
    // R8 mode bit commands
    wr(1, 8'hA7); expect_ev("R8 aux off", 2'd0, 8'h23); wr(1, 8'h20);
    wr(1, 8'hA8); expect_ev("R8 aux on",  2'd0, 8'h03); wr(1, 8'h20);
    wr(1, 8'hAD); expect_ev("R8 kbd off", 2'd0, 8'h13); wr(1, 8'h20);
    wr(1, 8'hAE); expect_ev("R8 kbd on",  2'd0, 8'h03); wr(1, 8'h20);
    // R9 A20 control
    wr(1, 8'hDD);
    check("R9 gate low", {9'd0, a20}, 10'd0);
    expect_ev("R9 port low", 2'd0, 8'hCD);        wr(1, 8'hD0);
    wr(1, 8'hDF);
    check("R9 gate high", {9'd0, a20}, 10'd1);
    wr(1, 8'hD1); wr(0, 8'hCD);
    check("R9 port write a20", {8'd0, a20, cpu_rst}, 10'd0);
    wr(1, 8'hD1); wr(0, 8'hCF);
    check("R9 port write a20 hi", {8'd0, a20, cpu_rst}, 10'd2);
    // R10 pulse family
    wr(1, 8'hF1); check("R10 F1 no pulse", {9'd0, cpu_rst}, 10'd0);
    wr(1, 8'hFF); check("R10 FF no pulse", {9'd0, cpu_rst}, 10'd0);
    wr(1, 8'hFE); pulse_len("R10 FE pulse length", PULSE_EXP);
    wr(1, 8'hF0); pulse_len("R10 F0 pulse length", PULSE_EXP);
    // R11 reset through output-port write, A20 kept high
    wr(1, 8'hD1); wr(0, 8'hCE);
    check("R11 a20 kept", {9'd0, a20}, 10'd1);
    pulse_len("R11 port pulse length", PULSE_EXP);
    wr(1, 8'hD1); wr(0, 8'hCF);
    check("R11 no pulse on bit0 high", {9'd0, cpu_rst}, 10'd0);
    // R12 pending flags and interrupts
    kbd_pend = 1'b1; #1;
    status_is("R12 kbd pend", 8'h21, 8'h01);
    check("R12 irq kbd", {8'd0, irq_kbd, irq_aux}, 10'd2);
    aux_pend = 1'b1; #1;
    status_is("R12 both pend", 8'h21, 8'h01);
    check("R12 kbd wins", {8'd0, irq_kbd, irq_aux}, 10'd2);
    wr(1, 8'hAD);
    check("R12 kbd masked", {8'd0, irq_kbd, irq_aux}, 10'd0);
    wr(1, 8'hAE);
    kbd_pend = 1'b0; #1;
    status_is("R12 aux only", 8'h21, 8'h21);
    check("R12 irq aux", {8'd0, irq_kbd, irq_aux}, 10'd1);
    expect_ev("R12 port view", 2'd0, 8'hFF);      wr(1, 8'hD0);
    aux_pend = 1'b0;
    // R13 unsupported codes
    wr(1, 8'h12); wr(1, 8'hB5); wr(1, 8'hE0);
    check("R13 no pulse", {9'd0, cpu_rst}, 10'd0);
    status_is("R13 status", 8'hFF, 8'h1C);
    expect_ev("R13 mode kept", 2'd0, 8'h03);      wr(1, 8'h20);
    expect_ev("R13 port kept", 2'd0, 8'hCF);      wr(1, 8'hD0);
    // R14 data read
    rq_head = 8'hA5; host_sel = 1'b0; host_re = 1'b1; #1;
    check("R14 read data", {2'b00, host_rdata}, 10'h0A5);
    check("R14 pop", {9'd0, rq_pop}, 10'd1);
    host_re = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 all events seen", 10'(exp_q.size()), 10'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule